// File: doc/BRIEF.md
# Acquire/Release Ordering Issue Gate

This block sits between one processor's in-order stream of memory requests and the memory system. Each request carries a class: an ordinary load/store, an acquire, or a release. The gate decides, one request at a time, whether the head request may issue now. If it may not, it holds the stream. The rules it applies are one-directional. An ordinary access must wait for every earlier acquire to complete. A release must wait for every earlier ordinary access to complete. Ordinary accesses that follow a release do not wait for that release. Acquires and releases stay ordered among themselves.

The memory side returns completions, one per cycle at most, each tagged with the class of the operation that finished. The gate keeps a separate outstanding count per class. It increments the matching count when it accepts a request and decrements it on a completion of that class. Ordinary accesses are not ordered against each other, so several may be in flight at once. Each count is bounded by a parameter, and a class at its limit stalls. Accepted requests appear on a registered issue port one cycle after acceptance.

Class codes on both the request and completion buses: 2'b00 ordinary, 2'b01 acquire, 2'b10 release.

Top module: `rc_issue_gate`

## Requirements
- R1: After reset, iss_valid is 0, all outstanding counts are zero, and an ordinary request (code 2'b00) is accepted at once.
- R2: An ordinary request is not accepted while any acquire (code 2'b01) is outstanding, and it is accepted in the first cycle after the last acquire completes.
- R3: A release (code 2'b10) is not accepted while any ordinary access is outstanding.
- R4: An ordinary request is accepted while a release is outstanding.
- R5: An acquire is accepted while ordinary accesses are outstanding, but not while any acquire or release is outstanding.
- R6: A release is not accepted while any acquire or release is outstanding.
- R7: Ordinary requests are accepted back to back, with no completion needed between them.
- R8: A class with MAX_OUT outstanding operations stalls further requests of that class, and no count exceeds MAX_OUT.
- R9: A request accepted in cycle t (req_valid and req_ready high) appears on iss_valid, iss_class and iss_tag in cycle t+1. A request that is stalled produces no issue.
- R10: A completion and an acceptance of the same class in the same cycle leave that class's count unchanged.
- R11: A completion for a class with nothing outstanding is ignored, and the count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Head request present |
| req_class | input | 2 | Head request class code |
| req_tag | input | TAG_W | Opaque request identifier |
| req_ready | output | 1 | Head request accepted this cycle |
| iss_valid | output | 1 | Registered issue strobe |
| iss_class | output | 2 | Class of the issued request |
| iss_tag | output | TAG_W | Tag of the issued request |
| cpl_valid | input | 1 | A completion arrives |
| cpl_class | input | 2 | Class of the completed operation |

## Verification
A completion and an acceptance can fall in the same cycle. When they target the same class, they must cancel in that class's count. The bench fills the ordinary count to its limit, drains it by one, and then presents an ordinary request together with an ordinary completion. The effect is judged at the ports: exactly one more ordinary request must be accepted before the gate stalls again, and the gate must only let a release through after the expected number of further completions. A stray completion at zero would be the same kind of collision, with nothing to cancel against. It is judged in the same way, by whether a release is still accepted afterwards.

// File: rtl/rc_gate_pkg.sv
package rc_gate_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'b00,
    OP_ACQ   = 2'b01,
    OP_REL   = 2'b10
  } op_cls_e;

  localparam int NUM_CLS = 3;

  function automatic logic cls_known(input logic [1:0] c);
    return (c == OP_PLAIN) || (c == OP_ACQ) || (c == OP_REL);
  endfunction
endpackage

// File: rtl/rc_out_ctr.sv
module rc_out_ctr #(
  parameter int MAX_OUT = 4,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             zero,
  output logic             full
);
  // a decrement at zero is dropped, an increment at full never arrives
  logic dec_ok;
  assign dec_ok = dec && (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && !dec_ok) begin
      count <= count + 1'b1;
    end else if (dec_ok && !inc) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);
  assign full = (count == CNT_W'(MAX_OUT));

  // R8
  cnt_le_max_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(MAX_OUT));

  // R11
  idle_cpl_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && zero && !inc) |=> zero);

  // R10
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && dec && !zero) |=> $stable(count));
endmodule

// File: rtl/rc_issue_rules.sv
module rc_issue_rules
  import rc_gate_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_class,
  input  logic       plain_zero,
  input  logic       plain_full,
  input  logic       acq_zero,
  input  logic       acq_full,
  input  logic       rel_zero,
  input  logic       rel_full,
  output logic       grant
);
  logic specials_idle;
  assign specials_idle = acq_zero && rel_zero;

  always_comb begin
    grant = 1'b0;
    if (req_valid) begin
      unique case (req_class)
        OP_PLAIN: grant = acq_zero && !plain_full;
        OP_ACQ:   grant = specials_idle && !acq_full;
        OP_REL:   grant = specials_idle && plain_zero && !rel_full;
        default:  grant = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rc_issue_reg.sv
module rc_issue_reg #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [1:0]       in_class,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [1:0]       out_class,
  output logic [TAG_W-1:0] out_tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_class <= 2'b00;
      out_tag   <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_class <= in_class;
        out_tag   <= in_tag;
      end
    end
  end
endmodule

// File: rtl/rc_issue_gate.sv
module rc_issue_gate
  import rc_gate_pkg::*;
#(
  parameter int MAX_OUT = 4,
  parameter int TAG_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_class,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic             iss_valid,
  output logic [1:0]       iss_class,
  output logic [TAG_W-1:0] iss_tag,
  input  logic             cpl_valid,
  input  logic [1:0]       cpl_class
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [NUM_CLS-1:0] cls_zero;
  logic [NUM_CLS-1:0] cls_full;
  logic [CNT_W-1:0]   cls_cnt [NUM_CLS];
  logic               grant;

  genvar g;
  generate
    for (g = 0; g < NUM_CLS; g++) begin : g_ctr
      logic inc_g, dec_g;
      assign inc_g = grant && (req_class == 2'(g));
      assign dec_g = cpl_valid && (cpl_class == 2'(g));
      rc_out_ctr #(.MAX_OUT(MAX_OUT)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc_g),
        .dec   (dec_g),
        .count (cls_cnt[g]),
        .zero  (cls_zero[g]),
        .full  (cls_full[g])
      );
    end
  endgenerate

  rc_issue_rules u_rules (
    .req_valid  (req_valid),
    .req_class  (req_class),
    .plain_zero (cls_zero[OP_PLAIN]),
    .plain_full (cls_full[OP_PLAIN]),
    .acq_zero   (cls_zero[OP_ACQ]),
    .acq_full   (cls_full[OP_ACQ]),
    .rel_zero   (cls_zero[OP_REL]),
    .rel_full   (cls_full[OP_REL]),
    .grant      (grant)
  );

  assign req_ready = grant;

  rc_issue_reg #(.TAG_W(TAG_W)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .fire      (grant),
    .in_class  (req_class),
    .in_tag    (req_tag),
    .out_valid (iss_valid),
    .out_class (iss_class),
    .out_tag   (iss_tag)
  );

  // R2
  plain_after_acq_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_class == OP_PLAIN) |-> cls_zero[OP_ACQ]);

  // R3
  rel_after_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_class == OP_REL) |-> cls_zero[OP_PLAIN]);

  // R5
  acq_after_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_class == OP_ACQ) |-> cls_zero[OP_REL]);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> !iss_valid);

  // R9
  issue_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (iss_valid && iss_tag == $past(req_tag)));
endmodule

// File: tb/rc_issue_gate_tb.sv
module rc_issue_gate_tb;
  localparam int TAG_W = 8;
  localparam logic [1:0] PL = 2'b00, AQ = 2'b01, RL = 2'b10;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, cpl_valid;
  logic [1:0] req_class, cpl_class;
  logic [TAG_W-1:0] req_tag;
  logic req_ready, iss_valid;
  logic [1:0] iss_class;
  logic [TAG_W-1:0] iss_tag;
  int n_chk = 0, n_fail = 0;

  always #2ns clk = ~clk;

  rc_issue_gate #(.MAX_OUT(4), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_class(req_class), .req_tag(req_tag),
    .req_ready(req_ready),
    .iss_valid(iss_valid), .iss_class(iss_class), .iss_tag(iss_tag),
    .cpl_valid(cpl_valid), .cpl_class(cpl_class)
  );

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge with inputs idle
  task automatic step(input logic rv, input logic [1:0] rc, input logic [7:0] rt,
                      input logic cv, input logic [1:0] cc,
                      input logic exp_rdy, input string rq);
    logic ei;
    ei = rv && exp_rdy;
    req_valid = rv; req_class = rc; req_tag = rt;
    cpl_valid = cv; cpl_class = cc;
    #1ns;
    if (rv) chk(req_ready == exp_rdy, {rq, " ready"}, int'(req_ready), int'(exp_rdy));
    @(posedge clk);
    @(negedge clk);
    chk(iss_valid == ei, {rq, " iss_valid"}, int'(iss_valid), int'(ei));
    if (ei) begin
      chk(iss_class == rc, {rq, " iss_class"}, int'(iss_class), int'(rc));
      chk(iss_tag == rt, {rq, " iss_tag"}, int'(iss_tag), int'(rt));
    end
    req_valid = 1'b0; cpl_valid = 1'b0;
  endtask

  task automatic cpl(input logic [1:0] c);
    step(1'b0, PL, 8'h00, 1'b1, c, 1'b0, "cpl");
  endtask

  task automatic t_reset;
    chk(iss_valid == 1'b0, "R1 reset iss_valid", int'(iss_valid), 0);
    step(1'b1, PL, 8'h11, 1'b0, PL, 1'b1, "R1 first plain");
    cpl(PL);
  endtask

  task automatic t_acquire_blocks;
    step(1'b1, AQ, 8'h21, 1'b0, PL, 1'b1, "R5 acquire idle");
    step(1'b1, PL, 8'h22, 1'b0, PL, 1'b0, "R2 plain behind acquire");
    cpl(AQ);
    step(1'b1, PL, 8'h23, 1'b0, PL, 1'b1, "R2 plain after acquire done");
    cpl(PL);
  endtask

  task automatic t_release_paths;
    step(1'b1, PL, 8'h31, 1'b0, PL, 1'b1, "R7 plain a");
    step(1'b1, PL, 8'h32, 1'b0, PL, 1'b1, "R7 plain b");
    step(1'b1, RL, 8'h33, 1'b0, PL, 1'b0, "R3 release two plains out");
    cpl(PL);
    step(1'b1, RL, 8'h34, 1'b0, PL, 1'b0, "R3 release one plain out");
    cpl(PL);
    step(1'b1, RL, 8'h35, 1'b0, PL, 1'b1, "R3 release plains done");
    step(1'b1, PL, 8'h36, 1'b0, PL, 1'b1, "R4 plain past release");
    step(1'b1, AQ, 8'h37, 1'b0, PL, 1'b0, "R5 acquire behind release");
    step(1'b1, RL, 8'h38, 1'b0, PL, 1'b0, "R6 release behind release");
    cpl(RL);
    step(1'b1, AQ, 8'h39, 1'b0, PL, 1'b1, "R5 acquire with plain out");
    step(1'b1, RL, 8'h3a, 1'b0, PL, 1'b0, "R6 release behind acquire");
    step(1'b1, AQ, 8'h3b, 1'b0, PL, 1'b0, "R5 acquire behind acquire");
    step(1'b1, PL, 8'h3c, 1'b0, PL, 1'b0, "R2 plain behind acquire");
    cpl(AQ);
    cpl(PL);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 4; i++)
      step(1'b1, PL, 8'(8'h40 + i), 1'b0, PL, 1'b1, "R7 fill plain");
    step(1'b1, PL, 8'h44, 1'b0, PL, 1'b0, "R8 plain at limit");
    cpl(PL);
    step(1'b1, PL, 8'h45, 1'b1, PL, 1'b1, "R10 plain with completion");
    step(1'b1, PL, 8'h46, 1'b0, PL, 1'b1, "R10 one slot left");
    step(1'b1, PL, 8'h47, 1'b0, PL, 1'b0, "R10 R8 full again");
    for (int i = 0; i < 3; i++) cpl(PL);
    step(1'b1, RL, 8'h48, 1'b0, PL, 1'b0, "R10 one plain remains");
    cpl(PL);
    step(1'b1, RL, 8'h49, 1'b0, PL, 1'b1, "R10 all plains drained");
    cpl(RL);
  endtask

  task automatic t_stray;
    cpl(AQ);
    step(1'b1, PL, 8'h51, 1'b0, PL, 1'b1, "R11 stray acquire completion");
    cpl(PL);
    cpl(PL);
    step(1'b1, RL, 8'h52, 1'b0, PL, 1'b1, "R11 stray plain completion");
    cpl(RL);
    cpl(RL);
    step(1'b1, AQ, 8'h53, 1'b0, PL, 1'b1, "R11 stray release completion");
    cpl(AQ);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_class = PL; req_tag = '0;
    cpl_valid = 1'b0; cpl_class = PL;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_acquire_blocks();
    t_release_paths();
    t_saturate();
    t_stray();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule